// File: doc/BRIEF.md
# Dual-Channel Sample Demultiplexing Output Formatter

This block sits behind a two-channel converter core. Each sample period it takes one pair of words, one from the I channel and one from the Q channel, and places them on four parallel output buses: a primary and a delayed bus for I (`out_i`, `out_id`) and the same for Q (`out_q`, `out_qd`). Each bus has its own out-of-range flag. The block sets the sample pace for the source through a one-cycle `pair_tick`. In the cycle it is high, the source must present the next pair. One sample period lasts `PAIR_CYC` fast clocks.

Four routing modes come from two settings: splitting (one or two sample pairs per output word) and interleaving (I and Q treated as two independent channels, or as one logical channel sampled on alternating phases). In interleaved operation the Q word of a pair is the older sample and the I word is the newer one. The block also drives a registered data clock `dclk` that follows the output words. In single-rate form `dclk` has one period per word, and the launch edge is selectable. In double-rate form it toggles once per word. The choice between single and double rate does not change how often the words themselves change. All mode inputs are static: they are captured only while `idle` is high.

Top module: `adc_dmx_fmt`

## Requirements
- R1: While reset is asserted, and after reset until `idle` is first raised, the mode is single-pair, non-interleaved, single-rate with rising launch. All buses and flags, `word_stb`, `dclk` and `pair_tick` are 0 while reset is asserted.
- R2: While `idle` is low, `pair_tick` is high for one cycle out of every `PAIR_CYC`. The first pulse comes in the cycle after the first clock edge that sees `idle` low. `pair_tick` is low in the cycle after any edge that sees `idle` high.
- R3: In the non-split, non-interleaved mode, each pair forms one word: `out_i` carries the I sample and `out_q` carries the Q sample. `out_id`, `out_qd` and their flags are 0. Each flag copies the flag of the sample on its bus.
- R4: In the non-split, interleaved mode, each pair forms one word: the older sample (Q) goes on `out_q` and the newer one (I) on `out_i`. Flags follow their samples.
- R5: In the split, non-interleaved mode, two pairs form one word: the first pair goes on `out_id` and `out_qd`, the second on `out_i` and `out_q`. Flags follow their samples.
- R6: In the split, interleaved mode, one word carries four samples of one stream. From oldest to newest they sit on `out_qd`, `out_id`, `out_q`, `out_i`.
- R7: All buses and flags change together, on the clock edge that samples the last pair of a word. `word_stb` is high for exactly that following cycle. Outputs hold at every other edge.
- R8: In single rate, `dclk` goes to the launch level (1 for rising launch, 0 for falling launch, selected by `cfg_fall`) at each word update. It returns to the opposite level half a word period later (`PAIR_CYC/2` clocks unsplit, `PAIR_CYC` clocks split). While idle and before the first word, it rests at the opposite level.
- R9: In double rate, `dclk` rests at 0 while idle and inverts at every word update.
- R10: The interval between words is `PAIR_CYC` clocks unsplit and `2*PAIR_CYC` clocks split, whatever the rate and launch-edge settings.
- R11: Changing mode inputs while `idle` is low has no effect on routing, pace or `dclk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle | input | 1 | Halts sampling; mode inputs are captured while high |
| cfg_demux | input | 1 | 1: two pairs per output word |
| cfg_des | input | 1 | 1: I and Q form one interleaved stream |
| cfg_ddr | input | 1 | 1: double-rate data clock |
| cfg_fall | input | 1 | Single rate: 1 launches data with the falling `dclk` edge |
| pair_tick | output | 1 | Source must present the next pair in this cycle |
| smp_i | input | SW | I channel sample |
| smp_q | input | SW | Q channel sample |
| smp_or_i | input | 1 | I sample out-of-range |
| smp_or_q | input | 1 | Q sample out-of-range |
| out_i | output | SW | I primary bus (newest I) |
| out_id | output | SW | I delayed bus (older I) |
| out_q | output | SW | Q primary bus (newest Q) |
| out_qd | output | SW | Q delayed bus (older Q) |
| or_i | output | 1 | Flag of `out_i` |
| or_id | output | 1 | Flag of `out_id` |
| or_q | output | 1 | Flag of `out_q` |
| or_qd | output | 1 | Flag of `out_qd` |
| word_stb | output | 1 | One-cycle marker of a new output word |
| dclk | output | 1 | Registered data clock |

## Verification
The bench builds the block with `SW=8`, `PAIR_CYC=2` and demultiplexing support present. At this shortest legal sample period, the single-rate half period of an unsplit word is one clock. This exposes off-by-one errors in the data-clock counter and in the tick spacing. The bench sweeps all sixteen combinations of split, interleave, rate and launch edge. It feeds a counting stream and rebuilds the expected bus contents, flags and `dclk` level for every cycle by arithmetic. It also checks the reset-default mode and mode changes made while running.

// File: rtl/adc_dmx_pkg.sv
package adc_dmx_pkg;

   typedef struct packed {
      logic demux;
      logic des;
      logic ddr;
      logic fall;
   } dmx_mode_t;

   typedef enum logic [1:0] {
      RT_SINGLE = 2'd0,
      RT_DES2   = 2'd1,
      RT_SPLIT2 = 2'd2,
      RT_SPLIT4 = 2'd3
   } dmx_route_e;

   function automatic dmx_route_e route_of(input dmx_mode_t m);
      dmx_route_e r;
      case ({m.demux, m.des})
         2'b00:   r = RT_SINGLE;
         2'b01:   r = RT_DES2;
         2'b10:   r = RT_SPLIT2;
         default: r = RT_SPLIT4;
      endcase
      return r;
   endfunction

   function automatic logic two_pairs(input dmx_route_e r);
      logic t;
      case (r)
         RT_SINGLE, RT_DES2:  t = 1'b0;
         RT_SPLIT2, RT_SPLIT4: t = 1'b1;
         default:             t = 1'b0;
      endcase
      return t;
   endfunction

endpackage

// File: rtl/adc_dmx_cfg.sv
module adc_dmx_cfg
   import adc_dmx_pkg::*;
#(
   parameter bit HAS_DEMUX = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      idle,
   input  logic      cfg_demux,
   input  logic      cfg_des,
   input  logic      cfg_ddr,
   input  logic      cfg_fall,
   output dmx_mode_t mode_q,
   output logic      split
);

   dmx_mode_t mode_nxt;

   generate
      if (HAS_DEMUX) begin : g_dmx
         assign mode_nxt.demux = cfg_demux;
      end else begin : g_nodmx
         assign mode_nxt.demux = 1'b0;
      end
   endgenerate

   assign mode_nxt.des  = cfg_des;
   assign mode_nxt.ddr  = cfg_ddr;
   assign mode_nxt.fall = cfg_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mode_q <= '0;
      else if (idle) mode_q <= mode_nxt;
   end

   assign split = two_pairs(route_of(mode_q));

endmodule

// File: rtl/adc_dmx_pace.sv
module adc_dmx_pace #(
   parameter int PAIR_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic idle,
   input  logic split,
   output logic pair_tick,
   output logic take,
   output logic word_evt
);

   localparam int CW = (PAIR_CYC > 1) ? $clog2(PAIR_CYC) : 1;
   localparam logic [CW-1:0] CYC_LAST = CW'(PAIR_CYC - 1);

   logic          live;
   logic [CW-1:0] cyc;
   logic          slot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live <= 1'b0;
         cyc  <= '0;
         slot <= 1'b0;
      end else if (idle) begin
         live <= 1'b0;
         cyc  <= '0;
         slot <= 1'b0;
      end else begin
         live <= 1'b1;
         if (live) cyc <= (cyc == CYC_LAST) ? '0 : cyc + 1'b1;
         if (take) slot <= split ? ~slot : 1'b0;
      end
   end

   assign pair_tick = live && (cyc == '0);
   assign take      = pair_tick && !idle;
   assign word_evt  = take && (!split || slot);

endmodule

// File: rtl/adc_dmx_lane.sv
module adc_dmx_lane #(
   parameter int SW        = 8,
   parameter bit HAS_DEMUX = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          last,
   input  logic          split,
   input  logic [SW-1:0] smp,
   input  logic          smp_or,
   output logic [SW-1:0] bus_new,
   output logic [SW-1:0] bus_old,
   output logic          flg_new,
   output logic          flg_old
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_new <= '0;
         flg_new <= 1'b0;
      end else if (take && last) begin
         bus_new <= smp;
         flg_new <= smp_or;
      end
   end

   generate
      if (HAS_DEMUX) begin : g_hold
         logic [SW-1:0] hold;
         logic          hold_or;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hold    <= '0;
               hold_or <= 1'b0;
               bus_old <= '0;
               flg_old <= 1'b0;
            end else if (take) begin
               if (last) begin
                  bus_old <= split ? hold : '0;
                  flg_old <= split && hold_or;
               end else begin
                  hold    <= smp;
                  hold_or <= smp_or;
               end
            end
         end
      end else begin : g_nohold
         assign bus_old = '0;
         assign flg_old = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/adc_dmx_dclk.sv
module adc_dmx_dclk #(
   parameter int PAIR_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic idle,
   input  logic word_evt,
   input  logic ddr,
   input  logic fall,
   input  logic split,
   output logic dclk
);

   localparam int DW = $clog2(2 * PAIR_CYC) + 1;
   localparam logic [DW-1:0] HALF1_UNSPLIT = DW'(PAIR_CYC / 2 - 1);
   localparam logic [DW-1:0] HALF1_SPLIT   = DW'(PAIR_CYC - 1);

   logic [DW-1:0] dcnt;
   logic          primed;
   logic [DW-1:0] half_m1;

   assign half_m1 = split ? HALF1_SPLIT : HALF1_UNSPLIT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dclk   <= 1'b0;
         dcnt   <= '0;
         primed <= 1'b0;
      end else if (idle) begin
         dclk   <= ddr ? 1'b0 : fall;
         dcnt   <= '0;
         primed <= 1'b0;
      end else if (word_evt) begin
         dclk   <= ddr ? ~dclk : ~fall;
         dcnt   <= '0;
         primed <= 1'b1;
      end else begin
         if (dcnt != '1) dcnt <= dcnt + 1'b1;
         if (!ddr && primed && (dcnt == half_m1)) dclk <= fall;
      end
   end

endmodule

// File: rtl/adc_dmx_fmt.sv
module adc_dmx_fmt
   import adc_dmx_pkg::*;
#(
   parameter int SW        = 8,
   parameter int PAIR_CYC  = 2,
   parameter bit HAS_DEMUX = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          idle,
   input  logic          cfg_demux,
   input  logic          cfg_des,
   input  logic          cfg_ddr,
   input  logic          cfg_fall,
   output logic          pair_tick,
   input  logic [SW-1:0] smp_i,
   input  logic [SW-1:0] smp_q,
   input  logic          smp_or_i,
   input  logic          smp_or_q,
   output logic [SW-1:0] out_i,
   output logic [SW-1:0] out_id,
   output logic [SW-1:0] out_q,
   output logic [SW-1:0] out_qd,
   output logic          or_i,
   output logic          or_id,
   output logic          or_q,
   output logic          or_qd,
   output logic          word_stb,
   output logic          dclk
);

   localparam int NCH = 2;

   generate
      if (SW < 1) begin : g_bad_sw
         $error("adc_dmx_fmt: SW must be at least 1");
      end
      if (PAIR_CYC < 2 || (PAIR_CYC % 2) != 0) begin : g_bad_pace
         $error("adc_dmx_fmt: PAIR_CYC must be even and at least 2");
      end
   endgenerate

   dmx_mode_t     mode_q;
   logic          split;
   logic          take;
   logic          word_evt;

   logic [SW-1:0] smp_a     [NCH];
   logic          smp_or_a  [NCH];
   logic [SW-1:0] bus_new_a [NCH];
   logic [SW-1:0] bus_old_a [NCH];
   logic          flg_new_a [NCH];
   logic          flg_old_a [NCH];

   adc_dmx_cfg #(.HAS_DEMUX(HAS_DEMUX)) i_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .idle      (idle),
      .cfg_demux (cfg_demux),
      .cfg_des   (cfg_des),
      .cfg_ddr   (cfg_ddr),
      .cfg_fall  (cfg_fall),
      .mode_q    (mode_q),
      .split     (split)
   );

   adc_dmx_pace #(.PAIR_CYC(PAIR_CYC)) i_pace (
      .clk       (clk),
      .rst_n     (rst_n),
      .idle      (idle),
      .split     (split),
      .pair_tick (pair_tick),
      .take      (take),
      .word_evt  (word_evt)
   );

   assign smp_a[0]    = smp_i;
   assign smp_a[1]    = smp_q;
   assign smp_or_a[0] = smp_or_i;
   assign smp_or_a[1] = smp_or_q;

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
         adc_dmx_lane #(.SW(SW), .HAS_DEMUX(HAS_DEMUX)) i_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .take    (take),
            .last    (word_evt),
            .split   (split),
            .smp     (smp_a[ch]),
            .smp_or  (smp_or_a[ch]),
            .bus_new (bus_new_a[ch]),
            .bus_old (bus_old_a[ch]),
            .flg_new (flg_new_a[ch]),
            .flg_old (flg_old_a[ch])
         );
      end
   endgenerate

   assign out_i  = bus_new_a[0];
   assign out_id = bus_old_a[0];
   assign out_q  = bus_new_a[1];
   assign out_qd = bus_old_a[1];
   assign or_i   = flg_new_a[0];
   assign or_id  = flg_old_a[0];
   assign or_q   = flg_new_a[1];
   assign or_qd  = flg_old_a[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_stb <= 1'b0;
      else        word_stb <= word_evt;
   end

   adc_dmx_dclk #(.PAIR_CYC(PAIR_CYC)) i_dclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .idle     (idle),
      .word_evt (word_evt),
      .ddr      (mode_q.ddr),
      .fall     (mode_q.fall),
      .split    (split),
      .dclk     (dclk)
   );

endmodule

// File: rtl/adc_dmx_fmt_chk.sv
module adc_dmx_fmt_chk
   import adc_dmx_pkg::*;
#(
   parameter int SW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          idle,
   input logic          pair_tick,
   input logic          word_stb,
   input logic          dclk,
   input dmx_mode_t     mode,
   input logic [SW-1:0] out_i,
   input logic [SW-1:0] out_id,
   input logic [SW-1:0] out_q,
   input logic [SW-1:0] out_qd,
   input logic          or_i,
   input logic          or_id,
   input logic          or_q,
   input logic          or_qd
);

   AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $past(idle) |-> !pair_tick); // R2

   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pair_tick |=> !pair_tick); // R2

   AST_WORD_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      word_stb |-> $past(pair_tick)); // R7

   AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      word_stb |=> !word_stb); // R10

   AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !word_stb |-> $stable({out_i, out_id, out_q, out_qd, or_i, or_id, or_q, or_qd})); // R7

   AST_UNSPLIT_OLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (word_stb && !mode.demux) |-> (out_id == '0 && out_qd == '0 && !or_id && !or_qd)); // R3

   AST_SDR_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      (word_stb && !mode.ddr) |-> (dclk == !mode.fall)); // R8

   AST_DDR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (word_stb && mode.ddr) |-> (dclk != $past(dclk))); // R9

endmodule

bind adc_dmx_fmt adc_dmx_fmt_chk #(.SW(SW)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .idle      (idle),
   .pair_tick (pair_tick),
   .word_stb  (word_stb),
   .dclk      (dclk),
   .mode      (mode_q),
   .out_i     (out_i),
   .out_id    (out_id),
   .out_q     (out_q),
   .out_qd    (out_qd),
   .or_i      (or_i),
   .or_id     (or_id),
   .or_q      (or_q),
   .or_qd     (or_qd)
);

// File: tb/test_adc_dmx_fmt.sv
module test_adc_dmx_fmt;

   localparam int CLK_PER  = 10;
   localparam int SW       = 8;
   localparam int PAIR_CYC = 2;

   logic          clk;
   logic          rst_n;
   logic          idle;
   logic          cfg_demux, cfg_des, cfg_ddr, cfg_fall;
   logic          pair_tick;
   logic [SW-1:0] smp_i, smp_q;
   logic          smp_or_i, smp_or_q;
   logic [SW-1:0] out_i, out_id, out_q, out_qd;
   logic          or_i, or_id, or_q, or_qd;
   logic          word_stb;
   logic          dclk;

   int errs   = 0;
   int checks = 0;
   bit done   = 0;

   adc_dmx_fmt #(.SW(SW), .PAIR_CYC(PAIR_CYC), .HAS_DEMUX(1'b1)) i_adc_dmx_fmt (
      .clk(clk), .rst_n(rst_n), .idle(idle),
      .cfg_demux(cfg_demux), .cfg_des(cfg_des), .cfg_ddr(cfg_ddr), .cfg_fall(cfg_fall),
      .pair_tick(pair_tick),
      .smp_i(smp_i), .smp_q(smp_q), .smp_or_i(smp_or_i), .smp_or_q(smp_or_q),
      .out_i(out_i), .out_id(out_id), .out_q(out_q), .out_qd(out_qd),
      .or_i(or_i), .or_id(or_id), .or_q(or_q), .or_qd(or_qd),
      .word_stb(word_stb), .dclk(dclk)
   );

   initial clk = 1'b0;
   always #(CLK_PER / 2) clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic flag_of(input logic [SW-1:0] v);
      return v[0] ^ v[2];
   endfunction

   function automatic logic [SW-1:0] i_val(input int p, input bit des);
      return des ? SW'(2 * p + 1) : SW'(p);
   endfunction

   function automatic logic [SW-1:0] q_val(input int p, input bit des);
      return des ? SW'(2 * p) : SW'(p + 128);
   endfunction

   task automatic run_config(input bit dmx, input bit des, input bit ddr, input bit fall,
                             input bit disturb, input bit keep_cfg);
      int            wlen, half, p, w, c, tgap;
      bit            seen, exp_dd, first;
      logic [SW-1:0] ei, eid, eq, eqd;
      logic [4*SW+3:0] snap;
      string         mt;
      wlen   = (dmx ? 2 : 1) * PAIR_CYC;
      half   = wlen / 2;
      p      = 0; w = 0; c = 0; tgap = 0;
      seen   = 0; exp_dd = 0; first = 1;
      snap   = '0;
      mt     = dmx ? (des ? "R6" : "R5") : (des ? "R4" : "R3");
      if (!keep_cfg) begin
         @(negedge clk);
         idle = 1'b1;
         cfg_demux = dmx; cfg_des = des; cfg_ddr = ddr; cfg_fall = fall;
         smp_i = '0; smp_q = '0; smp_or_i = 1'b0; smp_or_q = 1'b0;
         repeat (2) @(negedge clk);
         chk(ddr ? "R9 idle dclk rest" : "R8 idle dclk rest", dclk, ddr ? 0 : int'(fall));
         chk("R2 no tick while idle", pair_tick, 0);
         idle = 1'b0;
      end
      for (int t = 0; t < 14 * wlen + 2; t++) begin
         @(negedge clk);
         if (first) begin
            chk("R2 first tick", pair_tick, 1);
            first = 0;
         end
         if (pair_tick) begin
            if (p > 0) chk("R2 tick spacing", tgap, PAIR_CYC);
            tgap = 0;
         end
         if (word_stb) begin
            if (!dmx) begin
               ei = i_val(w, des); eq = q_val(w, des); eid = '0; eqd = '0;
            end else begin
               ei = i_val(2 * w + 1, des); eid = i_val(2 * w, des);
               eq = q_val(2 * w + 1, des); eqd = q_val(2 * w, des);
            end
            chk({mt, " out_i"},  out_i,  ei);
            chk({mt, " out_id"}, out_id, eid);
            chk({mt, " out_q"},  out_q,  eq);
            chk({mt, " out_qd"}, out_qd, eqd);
            chk({mt, " or_i"},   or_i,   flag_of(ei));
            chk({mt, " or_q"},   or_q,   flag_of(eq));
            chk({mt, " or_id"},  or_id,  dmx ? int'(flag_of(eid)) : 0);
            chk({mt, " or_qd"},  or_qd,  dmx ? int'(flag_of(eqd)) : 0);
            if (seen) chk("R10 word period", c + 1, wlen);
            if (ddr) exp_dd = ~exp_dd;
            seen = 1;
            c    = 0;
            w++;
            snap = {out_i, out_id, out_q, out_qd, or_i, or_id, or_q, or_qd};
         end else begin
            c++;
            if (seen) chk("R7 hold between words",
                          int'(snap == {out_i, out_id, out_q, out_qd, or_i, or_id, or_q, or_qd}), 1);
         end
         if (ddr) chk("R9 dclk level", dclk, int'(exp_dd));
         else if (!seen) chk("R8 dclk before first word", dclk, int'(fall));
         else chk("R8 dclk level", dclk, (c < half) ? int'(!fall) : int'(fall));
         if (disturb && t == 5) begin
            // R11: flip every mode input while running; nothing may follow it
            cfg_demux = ~cfg_demux; cfg_des = ~cfg_des;
            cfg_ddr = ~cfg_ddr; cfg_fall = ~cfg_fall;
         end
         if (pair_tick) begin
            smp_i = i_val(p, des); smp_q = q_val(p, des);
            smp_or_i = flag_of(smp_i); smp_or_q = flag_of(smp_q);
            p++;
         end
         tgap++;
      end
      chk("R7 words seen", int'(w >= 12), 1);
   endtask

   initial begin
      rst_n = 1'b0; idle = 1'b0;
      cfg_demux = 1'b1; cfg_des = 1'b1; cfg_ddr = 1'b1; cfg_fall = 1'b1;
      smp_i = '0; smp_q = '0; smp_or_i = 1'b0; smp_or_q = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 reset buses", int'({out_i, out_id, out_q, out_qd} == '0), 1);
      chk("R1 reset flags", int'({or_i, or_id, or_q, or_qd} == 4'b0), 1);
      chk("R1 reset word_stb", word_stb, 0);
      chk("R1 reset dclk", dclk, 0);
      chk("R1 reset pair_tick", pair_tick, 0);
      rst_n = 1'b1;
      // R1 default mode after reset, R11 mode inputs all high but idle never raised
      run_config(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      for (int m = 0; m < 16; m++) begin
         run_config(m[3], m[2], m[1], m[0], m[1] == m[0], 1'b0);
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #(CLK_PER * 100000);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule